// File: doc/BRIEF.md
# Unlock Sequence Decoder for a Byte-Wide Nonvolatile Memory Model

This block watches the byte-load cycles that a host issues to a parallel nonvolatile memory model. Each cycle presents a 17-bit address, a data byte and a one-cycle strobe. The block looks for fixed key byte sequences. A three-byte key selects one of three actions. An extended key of six bytes selects one of three further actions. For each recognised command the block emits a one-cycle pulse. It also keeps two state flags: a chip-wide write guard and an identification-read mode.

When the guard-arming command is recognised, the block sets the guard and opens a page-load window. While the window is open, every byte-load is passed to the page loader as data, and each one restarts the window timer. A byte that is not part of a key sequence is handled according to the guard. With the guard clear, the byte goes straight to the page loader. With the guard set, the byte is refused and starts a busy period, and the block ignores the bus until that period ends. Memory array, page buffer, bus timing and analog protection sit outside the block.

Top module: `unlock_seq_decoder`

## Requirements
- R1: Synchronous active-high reset clears the guard flag, the identification flag, the page window, the busy period, the load strobe and all command pulses.
- R2: The key pairs (data AAh at address 5555h, then 55h at 2AAAh) followed by A0h at 5555h produce `arm_pulse` one cycle after the third strobe, set `prot_on` in that same cycle (it stays set if already set), and open the page window.
- R3: While the window is open, every strobe appears one cycle later on `load_vld` with its address and data, even when it looks like a key byte, and restarts the window. The window accepts a strobe up to WIN_CYCLES cycles after the previous accepted byte and refuses one at WIN_CYCLES+1 cycles.
- R4: The three-byte key ending in 90h at 5555h sets `id_mode` and pulses `id_in_pulse`. The key ending in F0h clears `id_mode` and pulses `id_out_pulse`.
- R5: A third byte of 80h at 5555h leads to a second key pair. A sixth byte at 5555h then selects the action: 20h pulses `unprot_pulse` and clears `prot_on`, 10h pulses `erase_pulse`, and 60h acts as an alternate identification entry.
- R6: Only address bits 14..0 are compared. Bits 16 and 15 have no effect on matching.
- R7: A byte that does not match the expected next step sends the sequence back to idle and is treated as a plain byte. The exception is AAh at 5555h, which restarts the key at step one and is not treated as a plain byte.
- R8: With `prot_on` clear and no window open, a plain byte appears on `load_vld`, `load_addr` and `load_data` one cycle after its strobe.
- R9: With `prot_on` set and no window open, a plain byte is not loaded. Instead, `lock_busy` is high for exactly LOCK_CYCLES cycles starting the cycle after the strobe. Strobes that arrive while `lock_busy` is high change no state and produce no output.
- R10: Each command pulse lasts one cycle, and at most one command pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_vld | input | 1 | One-cycle byte-load strobe |
| bus_addr | input | 17 | Byte-load address |
| bus_data | input | 8 | Byte-load data |
| arm_pulse | output | 1 | Guard armed and page window granted |
| unprot_pulse | output | 1 | Guard cleared |
| erase_pulse | output | 1 | Whole-array erase requested |
| id_in_pulse | output | 1 | Identification mode entered |
| id_out_pulse | output | 1 | Identification mode left |
| prot_on | output | 1 | Chip-wide write guard flag |
| id_mode | output | 1 | Identification-read mode flag |
| page_open | output | 1 | Page-load window open |
| lock_busy | output | 1 | Refused-write busy period |
| load_vld | output | 1 | Byte forwarded to the page loader |
| load_addr | output | 17 | Forwarded address |
| load_data | output | 8 | Forwarded data |

## Verification
A vector table feeds every three-byte and six-byte command, with the upper address bits set on some key bytes. It also covers a wrong second byte, a repeated first key byte and a wrong command byte. These cases separate a clean abort from a restart, and a plain byte that is forwarded from one that is absorbed. Directed sequences then probe the edges of the page window one cycle inside and one cycle outside the limit. They also measure the exact length of the busy period, feed a full key sequence during that period to show it is ignored, and clear the guard before showing that plain bytes are forwarded again.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int CMP_W  = 15;

    localparam logic [CMP_W-1:0]  KEY_A_ADDR = 15'h5555;
    localparam logic [DATA_W-1:0] KEY_A_DATA = 8'hAA;
    localparam logic [CMP_W-1:0]  KEY_B_ADDR = 15'h2AAA;
    localparam logic [DATA_W-1:0] KEY_B_DATA = 8'h55;

    localparam logic [DATA_W-1:0] OP_ARM    = 8'hA0;
    localparam logic [DATA_W-1:0] OP_ID_IN  = 8'h90;
    localparam logic [DATA_W-1:0] OP_ID_OUT = 8'hF0;
    localparam logic [DATA_W-1:0] OP_EXT    = 8'h80;
    localparam logic [DATA_W-1:0] OP_UNPROT = 8'h20;
    localparam logic [DATA_W-1:0] OP_ERASE  = 8'h10;
    localparam logic [DATA_W-1:0] OP_ID_ALT = 8'h60;

    typedef enum logic [2:0] {
        ST_IDLE, ST_K1, ST_K2, ST_K3, ST_K4, ST_K5
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_PLAIN, CMD_ARM, CMD_UNPROT, CMD_ERASE, CMD_ID_IN, CMD_ID_OUT
    } cmd_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_beat_t;

    typedef struct packed {
        logic arm;
        logic unprot;
        logic erase;
        logic id_in;
        logic id_out;
    } pulse_t;

    function automatic logic beat_is(bus_beat_t b, logic [CMP_W-1:0] a, logic [DATA_W-1:0] d);
        return (b.addr[CMP_W-1:0] == a) && (b.data == d);
    endfunction

    function automatic logic at_key_a(bus_beat_t b);
        return b.addr[CMP_W-1:0] == KEY_A_ADDR;
    endfunction

endpackage

// File: rtl/unlock_seq_tracker.sv
module unlock_seq_tracker
    import unlock_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      beat_vld,
    input  bus_beat_t beat,
    output cmd_t      cmd
);

    seq_state_t state_q, state_d;
    logic       first_key;
    logic       matched;

    always_comb begin
        state_d   = state_q;
        cmd       = CMD_NONE;
        matched   = 1'b0;
        first_key = beat_is(beat, KEY_A_ADDR, KEY_A_DATA);
        if (beat_vld) begin
            case (state_q)
                ST_IDLE, ST_K3: begin
                    if (first_key) begin
                        matched = 1'b1;
                        state_d = (state_q == ST_IDLE) ? ST_K1 : ST_K4;
                    end
                end
                ST_K1, ST_K4: begin
                    if (beat_is(beat, KEY_B_ADDR, KEY_B_DATA)) begin
                        matched = 1'b1;
                        state_d = (state_q == ST_K1) ? ST_K2 : ST_K5;
                    end
                end
                ST_K2: begin
                    if (at_key_a(beat)) begin
                        case (beat.data)
                            OP_ARM:    begin matched = 1'b1; cmd = CMD_ARM;    state_d = ST_IDLE; end
                            OP_ID_IN:  begin matched = 1'b1; cmd = CMD_ID_IN;  state_d = ST_IDLE; end
                            OP_ID_OUT: begin matched = 1'b1; cmd = CMD_ID_OUT; state_d = ST_IDLE; end
                            OP_EXT:    begin matched = 1'b1; state_d = ST_K3; end
                            default:   matched = 1'b0;
                        endcase
                    end
                end
                ST_K5: begin
                    if (at_key_a(beat)) begin
                        case (beat.data)
                            OP_UNPROT: begin matched = 1'b1; cmd = CMD_UNPROT; state_d = ST_IDLE; end
                            OP_ERASE:  begin matched = 1'b1; cmd = CMD_ERASE;  state_d = ST_IDLE; end
                            OP_ID_ALT: begin matched = 1'b1; cmd = CMD_ID_IN;  state_d = ST_IDLE; end
                            default:   matched = 1'b0;
                        endcase
                    end
                end
                default: state_d = ST_IDLE;
            endcase
            if (!matched) begin
                if (first_key) begin
                    state_d = ST_K1;
                end else begin
                    state_d = ST_IDLE;
                    cmd     = CMD_PLAIN;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/unlock_down_timer.sv
module unlock_down_timer #(
    parameter int MAX = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic active
);

    localparam int W = (MAX < 2) ? 1 : $clog2(MAX + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= W'(MAX);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/unlock_cmd_exec.sv
module unlock_cmd_exec
    import unlock_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cmd_t      cmd,
    input  logic      win_hit,
    input  bus_beat_t beat,
    output pulse_t    pulses,
    output logic      prot_q,
    output logic      id_q,
    output logic      load_q,
    output bus_beat_t load_beat_q,
    output logic      lock_fire
);

    assign lock_fire = (cmd == CMD_PLAIN) && prot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulses      <= '0;
            prot_q      <= 1'b0;
            id_q        <= 1'b0;
            load_q      <= 1'b0;
            load_beat_q <= '0;
        end else begin
            pulses <= '0;
            load_q <= 1'b0;
            if (win_hit) begin
                load_q      <= 1'b1;
                load_beat_q <= beat;
            end
            case (cmd)
                CMD_ARM:    begin pulses.arm    <= 1'b1; prot_q <= 1'b1; end
                CMD_UNPROT: begin pulses.unprot <= 1'b1; prot_q <= 1'b0; end
                CMD_ERASE:  pulses.erase <= 1'b1;
                CMD_ID_IN:  begin pulses.id_in  <= 1'b1; id_q <= 1'b1; end
                CMD_ID_OUT: begin pulses.id_out <= 1'b1; id_q <= 1'b0; end
                CMD_PLAIN: begin
                    if (!prot_q) begin
                        load_q      <= 1'b1;
                        load_beat_q <= beat;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
    import unlock_seq_pkg::*;
#(
    parameter int WIN_CYCLES  = 16,
    parameter int LOCK_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_vld,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              arm_pulse,
    output logic              unprot_pulse,
    output logic              erase_pulse,
    output logic              id_in_pulse,
    output logic              id_out_pulse,
    output logic              prot_on,
    output logic              id_mode,
    output logic              page_open,
    output logic              lock_busy,
    output logic              load_vld,
    output logic [ADDR_W-1:0] load_addr,
    output logic [DATA_W-1:0] load_data
);

    localparam int N_TMR = 2;

    bus_beat_t beat, load_beat;
    pulse_t    pulses;
    cmd_t      cmd;
    logic      accepted, to_tracker, win_hit, lock_fire;
    logic [N_TMR-1:0] tmr_load, tmr_active;

    assign beat       = '{addr: bus_addr, data: bus_data};
    assign accepted   = bus_vld && !lock_busy;
    assign to_tracker = accepted && !page_open;
    assign win_hit    = accepted && page_open;

    unlock_seq_tracker u_track (
        .clk      (clk),
        .rst      (rst),
        .beat_vld (to_tracker),
        .beat     (beat),
        .cmd      (cmd)
    );

    unlock_cmd_exec u_exec (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .win_hit     (win_hit),
        .beat        (beat),
        .pulses      (pulses),
        .prot_q      (prot_on),
        .id_q        (id_mode),
        .load_q      (load_vld),
        .load_beat_q (load_beat),
        .lock_fire   (lock_fire)
    );

    assign tmr_load[0] = (cmd == CMD_ARM) || win_hit;
    assign tmr_load[1] = lock_fire;

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        localparam int LIM = (t == 0) ? WIN_CYCLES : LOCK_CYCLES;
        unlock_down_timer #(.MAX(LIM)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .load   (tmr_load[t]),
            .active (tmr_active[t])
        );
    end

    assign page_open    = tmr_active[0];
    assign lock_busy    = tmr_active[1];
    assign arm_pulse    = pulses.arm;
    assign unprot_pulse = pulses.unprot;
    assign erase_pulse  = pulses.erase;
    assign id_in_pulse  = pulses.id_in;
    assign id_out_pulse = pulses.id_out;
    assign load_addr    = load_beat.addr;
    assign load_data    = load_beat.data;

endmodule

// File: rtl/unlock_seq_checker.sv
module unlock_seq_checker (
    input logic clk,
    input logic rst,
    input logic arm_pulse,
    input logic unprot_pulse,
    input logic erase_pulse,
    input logic id_in_pulse,
    input logic id_out_pulse,
    input logic prot_on,
    input logic id_mode,
    input logic page_open,
    input logic lock_busy,
    input logic load_vld
);

    logic [4:0] pv;
    assign pv = {arm_pulse, unprot_pulse, erase_pulse, id_in_pulse, id_out_pulse};

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pv));

    assert_arm_sets_guard_R2: assert property (@(posedge clk) disable iff (rst)
        arm_pulse |-> prot_on);

    assert_guard_rise_needs_arm_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_on) |-> arm_pulse);

    assert_window_from_arm_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(page_open) |-> arm_pulse);

    assert_unprot_clears_R5: assert property (@(posedge clk) disable iff (rst)
        unprot_pulse |-> !prot_on);

    assert_id_enter_R4: assert property (@(posedge clk) disable iff (rst)
        id_in_pulse |-> id_mode);

    assert_id_leave_R4: assert property (@(posedge clk) disable iff (rst)
        id_out_pulse |-> !id_mode);

    assert_lock_only_guarded_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_busy) |-> (prot_on && !load_vld));

    assert_busy_is_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $past(lock_busy) |-> (pv == 5'b0 && !load_vld));

endmodule

bind unlock_seq_decoder unlock_seq_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .arm_pulse    (arm_pulse),
    .unprot_pulse (unprot_pulse),
    .erase_pulse  (erase_pulse),
    .id_in_pulse  (id_in_pulse),
    .id_out_pulse (id_out_pulse),
    .prot_on      (prot_on),
    .id_mode      (id_mode),
    .page_open    (page_open),
    .lock_busy    (lock_busy),
    .load_vld     (load_vld)
);

// File: tb/unlock_seq_decoder_tb.sv
module unlock_seq_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 16;
    localparam int LOCK = 12;
    localparam int NV   = 39;

    // entry: {addr17, data8, pulses{arm,unprot,erase,idin,idout,load}, prot, id}
    localparam logic [32:0] VEC [NV] = '{
        {17'h15555, 8'hAA, 6'b000000, 1'b0, 1'b0},  // R6 bit16 set
        {17'h02AAA, 8'h55, 6'b000000, 1'b0, 1'b0},
        {17'h05555, 8'h90, 6'b000100, 1'b0, 1'b1},  // R4 entry
        {17'h05555, 8'hAA, 6'b000000, 1'b0, 1'b1},
        {17'h0AAAA, 8'h55, 6'b000000, 1'b0, 1'b1},  // R6 bit15 set
        {17'h05555, 8'hF0, 6'b000010, 1'b0, 1'b0},  // R4 exit
        {17'h00123, 8'h3C, 6'b000001, 1'b0, 1'b0},  // R8 plain
        {17'h05555, 8'hAA, 6'b000000, 1'b0, 1'b0},
        {17'h02AAA, 8'h54, 6'b000001, 1'b0, 1'b0},  // R7 abort -> plain
        {17'h05555, 8'hAA, 6'b000000, 1'b0, 1'b0},
        {17'h05555, 8'hAA, 6'b000000, 1'b0, 1'b0},  // R7 restart
        {17'h02AAA, 8'h55, 6'b000000, 1'b0, 1'b0},
        {17'h05555, 8'h90, 6'b000100, 1'b0, 1'b1},
        {17'h05555, 8'hAA, 6'b000000, 1'b0, 1'b1},
        {17'h02AAA, 8'h55, 6'b000000, 1'b0, 1'b1},
        {17'h05555, 8'hF0, 6'b000010, 1'b0, 1'b0},
        {17'h05555, 8'hAA, 6'b000000, 1'b0, 1'b0},
        {17'h02AAA, 8'h55, 6'b000000, 1'b0, 1'b0},
        {17'h05555, 8'h80, 6'b000000, 1'b0, 1'b0},
        {17'h05555, 8'hAA, 6'b000000, 1'b0, 1'b0},
        {17'h02AAA, 8'h55, 6'b000000, 1'b0, 1'b0},
        {17'h05555, 8'h10, 6'b001000, 1'b0, 1'b0},  // R5 erase
        {17'h05555, 8'hAA, 6'b000000, 1'b0, 1'b0},
        {17'h02AAA, 8'h55, 6'b000000, 1'b0, 1'b0},
        {17'h05555, 8'h80, 6'b000000, 1'b0, 1'b0},
        {17'h05555, 8'hAA, 6'b000000, 1'b0, 1'b0},
        {17'h02AAA, 8'h55, 6'b000000, 1'b0, 1'b0},
        {17'h05555, 8'h60, 6'b000100, 1'b0, 1'b1},  // R5 alternate entry
        {17'h05555, 8'hAA, 6'b000000, 1'b0, 1'b1},
        {17'h02AAA, 8'h55, 6'b000000, 1'b0, 1'b1},
        {17'h05555, 8'hF0, 6'b000010, 1'b0, 1'b0},
        {17'h05555, 8'hAA, 6'b000000, 1'b0, 1'b0},
        {17'h02AAA, 8'h55, 6'b000000, 1'b0, 1'b0},
        {17'h05555, 8'h77, 6'b000001, 1'b0, 1'b0},  // R7 bad command byte
        {17'h05555, 8'hAA, 6'b000000, 1'b0, 1'b0},
        {17'h02AAA, 8'h55, 6'b000000, 1'b0, 1'b0},
        {17'h05555, 8'hA0, 6'b100000, 1'b1, 1'b0},  // R2 arm
        {17'h00100, 8'h11, 6'b000001, 1'b1, 1'b0},  // R3 window load
        {17'h05555, 8'hAA, 6'b000001, 1'b1, 1'b0}   // R3 key byte loaded as data
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_vld = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        arm_pulse, unprot_pulse, erase_pulse, id_in_pulse, id_out_pulse;
    logic        prot_on, id_mode, page_open, lock_busy, load_vld;
    logic [16:0] load_addr;
    logic [7:0]  load_data;

    int   n_checks = 0;
    int   n_errors = 0;
    logic [5:0]  obs;
    logic        obs_prot, obs_id, obs_busy;
    logic [16:0] obs_la;
    logic [7:0]  obs_ld;

    always #(CLK_PERIOD/2) clk = ~clk;

    unlock_seq_decoder #(.WIN_CYCLES(WIN), .LOCK_CYCLES(LOCK)) dut_i (
        .clk(clk), .rst(rst), .bus_vld(bus_vld), .bus_addr(bus_addr), .bus_data(bus_data),
        .arm_pulse(arm_pulse), .unprot_pulse(unprot_pulse), .erase_pulse(erase_pulse),
        .id_in_pulse(id_in_pulse), .id_out_pulse(id_out_pulse), .prot_on(prot_on),
        .id_mode(id_mode), .page_open(page_open), .lock_busy(lock_busy),
        .load_vld(load_vld), .load_addr(load_addr), .load_data(load_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sample();
        obs      = {arm_pulse, unprot_pulse, erase_pulse, id_in_pulse, id_out_pulse, load_vld};
        obs_prot = prot_on;
        obs_id   = id_mode;
        obs_busy = lock_busy;
        obs_la   = load_addr;
        obs_ld   = load_data;
    endtask

    task automatic put(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_addr = a; bus_data = d;
        @(negedge clk);
        bus_vld = 1'b0;
        sample();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic key3(input logic [7:0] op);
        put(17'h05555, 8'hAA);
        put(17'h02AAA, 8'h55);
        put(17'h05555, op);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        sample();
        check({obs, obs_prot, obs_id, obs_busy, page_open} == '0, "R1 reset state",
              {obs, obs_prot, obs_id, obs_busy, page_open}, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            put(VEC[i][32:16], VEC[i][15:8]);
            check({obs, obs_prot, obs_id} == VEC[i][7:0],
                  $sformatf("R2 R3 R4 R5 R6 R7 R8 vector %0d", i), {obs, obs_prot, obs_id}, VEC[i][7:0]);
            if (VEC[i][2])
                check({obs_la, obs_ld} == VEC[i][32:8],
                      $sformatf("R3 R8 forwarded beat %0d", i), {obs_la, obs_ld}, VEC[i][32:8]);
        end

        // R10: pulse gone the following cycle
        @(negedge clk);
        check(!arm_pulse && !id_in_pulse, "R10 pulse width", {arm_pulse, id_in_pulse}, 0);

        // R3: window edge, last accepted byte at edge E; accept at E+WIN
        idle(WIN - 3);
        put(17'h00140, 8'h5A);
        check(obs[0] && obs_la == 17'h00140 && obs_ld == 8'h5A, "R3 last cycle inside window",
              {obs[0], obs_la, obs_ld}, {1'b1, 17'h00140, 8'h5A});
        // refuse at E'+WIN+1
        idle(WIN - 1);
        put(17'h00141, 8'hA5);
        check(!obs[0], "R3 first cycle past window", obs[0], 0);
        check(obs_busy && obs_prot, "R9 guarded plain byte starts busy", {obs_busy, obs_prot}, 2'b11);

        // R9: key sequence during busy is ignored
        key3(8'h90);
        check(obs == '0 && !obs_id, "R9 bus ignored while busy", {obs, obs_id}, 0);
        while (lock_busy) @(negedge clk);
        check(!id_mode, "R9 no id entry after busy", id_mode, 0);

        // R9: busy length
        put(17'h00200, 8'h5A);
        cnt = obs_busy ? 1 : 0;
        check(!obs[0], "R9 guarded byte not loaded", obs[0], 0);
        @(negedge clk);
        while (lock_busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == LOCK, "R9 busy length", cnt, LOCK);

        // R5: clear the guard, then R8 plain forwarding
        put(17'h05555, 8'hAA); put(17'h02AAA, 8'h55); put(17'h05555, 8'h80);
        key3(8'h20);
        check(obs == 6'b010000 && !obs_prot, "R5 guard cleared", {obs, obs_prot}, 7'b0100000);
        put(17'h1FFFF, 8'hC3);
        check(obs[0] && obs_la == 17'h1FFFF && obs_ld == 8'hC3 && !obs_busy, "R8 plain byte after clear",
              {obs[0], obs_la, obs_ld}, {1'b1, 17'h1FFFF, 8'hC3});

        // R1: reset mid-run clears guard, window and id mode
        key3(8'h90);
        key3(8'hA0);
        check(obs_prot && obs_id && page_open, "R2 guard and window set", {obs_prot, obs_id, page_open}, 3'b111);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check({prot_on, id_mode, page_open, lock_busy, load_vld} == '0, "R1 reset after activity",
              {prot_on, id_mode, page_open, lock_busy, load_vld}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule